// File: doc/BRIEF.md
# Serial ADC command-response interface

This block holds the digital control and serial-port logic for a 12-bit successive-approximation converter. A host selects the block by pulling `cs_n` low and then clocks bits on `sclk`. Both sides launch bits on the falling edge and sample them on the rising edge. The block skips any zeros that arrive before the first one, which it treats as the start bit. It then takes a four-bit command. The command sets the channel code, chooses the result ordering, and either starts a conversion or asks for power shutdown.

During a conversion the block drives a trial code to an external DAC. It reads an external comparator on the next rising edge and keeps the trial bit when the comparator reports that the input is at or above the DAC level. Each result bit goes out on `sdo` as soon as it is decided. `sdo` stays undriven while the command arrives, so `sdi` and `sdo` can share one wire. The analog comparator, DAC, multiplexer and sample-and-hold are outside this block.

Top module: `serial_adc_ctrl`

## Requirements
- R1: `sdo_oe` is low while the block searches for the start bit and while it receives the command. Zeros on `sdi` before the first one do not start a command.
- R2: After the start bit the next four rising edges capture, in order, the single-ended flag, the odd/sign flag, the order flag and the convert flag. `ch_sel` becomes {single-ended, odd/sign}. `sdi` is ignored for the rest of the selection, and `ch_sel` keeps its value after deselect.
- R3: The falling edge after the convert flag is captured drives `sdo_oe` high and `sdo` low (null bit). The next twelve falling edges carry result bits 11 down to 0.
- R4: At the falling edge where result bit k is launched, and at the null-bit edge for bit 11, `dac_code` holds the bits already decided plus a one in the next lower position. When the comparator is sampled high the trial bit is kept. Once bit 0 is decided, `dac_code` equals the converted code.
- R5: With order flag 1, `sdo` is 0 on every falling edge after bit 0 until deselect.
- R6: With order flag 0, bits 1 up to 11 follow bit 0 on the next eleven falling edges, so bit 0 is sent once. `sdo` is 0 after that.
- R7: With convert flag 0, `shutdown` rises at the rising edge that captures the flag. After the null bit, twelve ones and then zeros are sent, and `dac_code` stays 0.
- R8: `shutdown` stays high after deselect. It clears at the first rising edge that sees `cs_n` low in the next selection, and a command in that same selection converts without delay.
- R9: A high `cs_n` drops `sdo_oe` at once and returns the block to the start-bit search at the next rising edge. A later selection then works normally.
- R10: `sh_en` is high from the rising edge that captures the start bit until the falling edge that launches the null bit. It is low at all other times.
- R11: `rst_n` low at a rising edge forces `sdo_oe`, `sh_en`, `dac_code`, `ch_sel` and `shutdown` to zero, even when `cs_n` is low and `sdi` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial bit clock; rising edge samples, falling edge launches |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts and idles the port |
| sdi | input | 1 | Serial command input |
| cmp | input | 1 | Comparator result, 1 when input is at or above the DAC level |
| sdo | output | 1 | Serial result output value |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| sh_en | output | 1 | Sample-and-hold tracking enable |
| ch_sel | output | 2 | Channel code {single-ended, odd/sign} |
| dac_code | output | RES_W | Trial code for the external DAC |
| shutdown | output | 1 | Power-shutdown request |

## Verification
Two events share one clock cycle with order flag 0. The rising edge that decides bit 0 is also the turn-around into the reversed tail, so the slot after bit 0 must already carry bit 1 and not a repeat of bit 0. The bench provokes this with codes whose bit 0 is 1 and 0, including all zeros and all ones, and checks every falling-edge slot against the code. Two events also share the first rising edge of a selection that follows a shutdown: `shutdown` clears on that edge while the start-bit search begins. The bench checks `shutdown` right after that edge and then checks a full conversion in the same selection.

// File: rtl/sadc_pkg.sv
// Shared types for the serial ADC command-response interface.
// Assumes one command word per chip-select cycle.
package sadc_pkg;

    // Number of command bits that follow the start bit.
    localparam int unsigned CMD_BITS = 4;

    // Transaction phase, advanced on rising sclk edges.
    typedef enum logic [1:0] {
        PH_HUNT = 2'd0,   // looking for the first one on sdi
        PH_CMD  = 2'd1,   // shifting in the command bits
        PH_RUN  = 2'd2    // converting / streaming, sdi ignored
    } phase_e;

    // Command word; field order is the arrival order, first bit in the MSB.
    typedef struct packed {
        logic single_end;  // channel code, upper bit
        logic odd_sign;    // channel code, lower bit
        logic msb_only;    // 1: MSB-first then zeros, 0: mirrored tail
        logic convert;     // 1: convert, 0: request shutdown
    } cmd_t;

endpackage

// File: rtl/sadc_cmd_rx.sv
// Command receiver: searches for the start bit, shifts in the command
// word, and holds the shutdown request across selections.
// Assumes sdi is stable around rising sclk edges and that cs_n is
// sampled on the same edges (high = abort).
module sadc_cmd_rx
    import sadc_pkg::*;
(
    input  logic   sclk,
    input  logic   rst_n,
    input  logic   cs_n,
    input  logic   sdi,
    output phase_e phase,
    output cmd_t   cmd,
    output logic   shutdown
);

    localparam int unsigned          CNT_W    = $clog2(CMD_BITS);
    localparam logic [CNT_W-1:0]     CNT_LAST = CNT_W'(CMD_BITS - 1);

    phase_e                 ph_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [CMD_BITS-2:0]    sr_q;
    cmd_t                   cmd_q;
    logic                   shut_q;
    logic                   last_bit;

    // Rising edge that takes the final command bit.
    assign last_bit = !cs_n && (ph_q == PH_CMD) && (cnt_q == CNT_LAST);

    // Phase sequencing and command bit counting.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            ph_q  <= PH_HUNT;
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (cs_n) begin
            ph_q  <= PH_HUNT;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_HUNT: begin
                    if (sdi) begin
                        ph_q  <= PH_CMD;
                        cnt_q <= '0;
                    end
                end
                PH_CMD: begin
                    sr_q  <= {sr_q[CMD_BITS-3:0], sdi};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_LAST) begin
                        ph_q <= PH_RUN;
                    end
                end
                default: ;
            endcase
        end
    end

    // Latch the full command word on its last bit.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (last_bit) begin
            cmd_q <= cmd_t'({sr_q, sdi});
        end
    end

    // Shutdown request: set by a zero convert bit, cleared in the next search.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            shut_q <= 1'b0;
        end else if (last_bit) begin
            shut_q <= ~sdi;
        end else if (!cs_n && ph_q == PH_HUNT) begin
            shut_q <= 1'b0;
        end
    end

    assign phase    = ph_q;
    assign cmd      = cmd_q;
    assign shutdown = shut_q;

    AST_SHUT_ON_REQUEST: assert property (@(posedge sclk) disable iff (!rst_n)
        (last_bit && !sdi) |=> shut_q); // R7
    AST_WAKE_IN_SEARCH: assert property (@(posedge sclk) disable iff (!rst_n)
        (!cs_n && ph_q == PH_HUNT) |=> !shut_q); // R8
    AST_ABORT_TO_SEARCH: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |=> (ph_q == PH_HUNT)); // R9

endmodule

// File: rtl/sadc_sar.sv
// Successive-approximation register: decides one bit per rising edge
// from the comparator and presents trial codes on falling edges.
// Assumes slot counts rising edges since the command completed and
// that the comparator settles within half a clock period.
module sadc_sar #(
    parameter int unsigned W  = 12,
    parameter int unsigned CW = 5
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          active,
    input  logic [CW-1:0] slot,
    input  logic          cmp,
    output logic [W-1:0]  result,
    output logic [W-1:0]  dac
);

    logic [W-1:0] sar_q;
    logic [W-1:0] trial;
    logic [W-1:0] dac_q;
    logic         conv_step;

    // One-hot trial bit for the position decided at the next rising edge.
    always_comb begin
        trial = '0;
        for (int i = 0; i < W; i++) begin
            if (active && slot == CW'(W - 1 - i)) begin
                trial[i] = 1'b1;
            end
        end
    end

    // Decide the current bit from the comparator; clear outside a conversion.
    always_ff @(posedge sclk) begin
        if (!rst_n || cs_n || !active) begin
            sar_q <= '0;
        end else begin
            for (int i = 0; i < W; i++) begin
                if (slot == CW'(W - 1 - i)) begin
                    sar_q[i] <= cmp;
                end
            end
        end
    end

    // Present decided bits plus trial bit to the DAC on the falling edge.
    always_ff @(negedge sclk) begin
        if (!rst_n || cs_n) begin
            dac_q <= '0;
        end else begin
            dac_q <= sar_q | trial;
        end
    end

    assign result    = sar_q;
    assign dac       = dac_q;
    assign conv_step = active && !cs_n && (slot < CW'(W));

    AST_DROP_ON_LOW: assert property (@(posedge sclk) disable iff (!rst_n)
        (conv_step && !cmp) |=> (sar_q == $past(sar_q))); // R4
    AST_KEEP_ON_HIGH: assert property (@(posedge sclk) disable iff (!rst_n)
        (conv_step && cmp) |=> (sar_q != $past(sar_q))); // R4

endmodule

// File: rtl/sadc_tx.sv
// Output sequencer: counts rising edges of the run phase and launches
// the null bit, MSB-first result, optional mirrored tail and zero fill
// on falling edges; also forms the sample-and-hold window.
// Assumes result bit W-n is decided at the n-th rising edge of the run.
module sadc_tx
    import sadc_pkg::*;
#(
    parameter int unsigned W  = 12,
    parameter int unsigned CW = 5
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  phase_e        phase,
    input  logic          msb_only,
    input  logic          convert,
    input  logic [W-1:0]  result,
    output logic [CW-1:0] slot,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          sh_en
);

    localparam logic [CW-1:0] SLOT_END = CW'(2 * W);

    logic [CW-1:0] slot_q;
    logic          nxt_bit;
    logic          bit_q;
    logic          oe_q;
    logic          win_q;

    // Run-phase edge counter, saturating once the tail is over.
    always_ff @(posedge sclk) begin
        if (!rst_n || cs_n || phase != PH_RUN) begin
            slot_q <= '0;
        end else if (slot_q != SLOT_END) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Select the bit for the coming falling edge from the slot number.
    always_comb begin
        nxt_bit = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (slot_q == CW'(W - i)) begin
                nxt_bit = convert ? result[i] : 1'b1;
            end
            if (i > 0 && slot_q == CW'(W + i) && convert && !msb_only) begin
                nxt_bit = result[i];
            end
        end
    end

    // Launch data, drive enable and sample window on the falling edge.
    always_ff @(negedge sclk) begin
        if (!rst_n || cs_n) begin
            bit_q <= 1'b0;
            oe_q  <= 1'b0;
            win_q <= 1'b0;
        end else begin
            bit_q <= nxt_bit;
            oe_q  <= (phase == PH_RUN);
            win_q <= (phase == PH_CMD);
        end
    end

    assign slot   = slot_q;
    assign sdo    = bit_q;
    assign sdo_oe = oe_q & ~cs_n;
    assign sh_en  = ~cs_n & ((phase == PH_CMD) | win_q);

    AST_HIZ_OUTSIDE_RUN: assert property (@(posedge sclk) disable iff (!rst_n)
        (phase != PH_RUN) |-> !oe_q); // R1
    AST_HOLD_IN_RUN: assert property (@(posedge sclk) disable iff (!rst_n)
        (phase == PH_RUN) |-> !sh_en); // R10

endmodule

// File: rtl/serial_adc_ctrl.sv
// Serial ADC command-response interface, top level.
// Joins the command receiver, the SAR engine and the output sequencer.
// Assumes external comparator, DAC, multiplexer and sample-and-hold, and
// an external pad that drives sdo when sdo_oe is high.
module serial_adc_ctrl
    import sadc_pkg::*;
#(
    parameter int unsigned RES_W = 12
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sdi,
    input  logic             cmp,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             sh_en,
    output logic [1:0]       ch_sel,
    output logic [RES_W-1:0] dac_code,
    output logic             shutdown
);

    localparam int unsigned SLOT_W = $clog2(2 * RES_W + 1);

    phase_e              phase;
    cmd_t                cmd;
    logic [SLOT_W-1:0]   slot;
    logic [RES_W-1:0]    result;
    logic                sar_active;

    assign sar_active = (phase == PH_RUN) && cmd.convert;

    sadc_cmd_rx u_cmd_rx (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .phase    (phase),
        .cmd      (cmd),
        .shutdown (shutdown)
    );

    sadc_sar #(.W(RES_W), .CW(SLOT_W)) u_sar (
        .sclk   (sclk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .active (sar_active),
        .slot   (slot),
        .cmp    (cmp),
        .result (result),
        .dac    (dac_code)
    );

    sadc_tx #(.W(RES_W), .CW(SLOT_W)) u_tx (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .phase    (phase),
        .msb_only (cmd.msb_only),
        .convert  (cmd.convert),
        .result   (result),
        .slot     (slot),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .sh_en    (sh_en)
    );

    assign ch_sel = {cmd.single_end, cmd.odd_sign};

    AST_DAC_IDLE_IN_SHUTDOWN: assert property (@(posedge sclk) disable iff (!rst_n)
        (phase == PH_RUN && !cmd.convert) |-> (dac_code == '0)); // R7

endmodule

// File: tb/serial_adc_ctrl_tb.sv
`timescale 1ns/1ps
module serial_adc_ctrl_tb;

    localparam int W = 12;

    logic         sclk  = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n  = 1'b1;
    logic         sdi   = 1'b0;
    logic [W-1:0] vin   = '0;
    logic         cmp;
    logic         sdo;
    logic         sdo_oe;
    logic         sh_en;
    logic [1:0]   ch_sel;
    logic [W-1:0] dac;
    logic         shutdown;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 sclk = ~sclk;

    // Comparator model: high when the input is at or above the DAC code.
    assign cmp = (vin >= dac);

    serial_adc_ctrl #(.RES_W(W)) u_dut (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .cmp      (cmp),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .sh_en    (sh_en),
        .ch_sel   (ch_sel),
        .dac_code (dac),
        .shutdown (shutdown)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic begin_txn();
        @(negedge sclk); #2;
        cs_n = 1'b0;
        sdi  = 1'b0;
    endtask

    task automatic end_txn();
        @(negedge sclk); #2;
        cs_n = 1'b1;
        sdi  = 1'b0;
        #1;
        chk("R9 drive released at deselect", sdo_oe, 0);
        repeat (2) @(negedge sclk);
    endtask

    task automatic send_head(input int lead, input bit sgl, input bit odd,
                             input bit msbf, input bit ps);
        logic [4:0] word;
        word = {1'b1, sgl, odd, msbf, ps};
        for (int i = 0; i < lead; i++) begin
            @(negedge sclk); #2;
            chk("R1 undriven during leading zeros", sdo_oe, 0);
            chk("R10 no sampling before start", sh_en, 0);
            sdi = 1'b0;
        end
        for (int i = 4; i >= 0; i--) begin
            @(negedge sclk); #2;
            chk("R1 undriven during command", sdo_oe, 0);
            chk("R10 sampling window in command", sh_en, (i < 4) ? 1 : 0);
            sdi = word[i];
        end
        @(posedge sclk); #2;
        chk("R10 sampling held past last command edge", sh_en, 1);
        chk("R7 shutdown flag follows convert bit", shutdown, ps ? 0 : 1);
        chk("R2 channel code", ch_sel, {sgl, odd});
    endtask

    task automatic read_stream(input bit msbf, input bit ps, input int slots);
        int code;
        int exp_dac;
        code = int'(vin);
        for (int n = 0; n < slots; n++) begin
            @(negedge sclk); #2;
            sdi = (n % 3 == 1);
            if (n == 0) begin
                chk("R3 null bit value", sdo, 0);
                chk("R3 drive on at null bit", sdo_oe, 1);
                chk("R10 sampling ends at null bit", sh_en, 0);
            end else if (n <= W) begin
                if (ps) chk("R3 MSB-first result bit", sdo, int'(vin[W-n]));
                else    chk("R7 shutdown ones", sdo, 1);
            end else if (n < 2 * W) begin
                if (ps && !msbf) chk("R6 mirrored tail bit", sdo, int'(vin[n-W]));
                else if (ps)     chk("R5 zero fill", sdo, 0);
                else             chk("R7 zeros after ones", sdo, 0);
            end else begin
                if (ps && !msbf) chk("R6 zeros after tail", sdo, 0);
                else if (ps)     chk("R5 zero fill late", sdo, 0);
                else             chk("R7 zeros late", sdo, 0);
            end
            if (ps && n <= W) begin
                if (n < W) exp_dac = ((code >> (W - n)) << (W - n)) | (1 << (W - 1 - n));
                else       exp_dac = code;
                chk("R4 DAC trial code", int'(dac), exp_dac);
            end else if (!ps) begin
                chk("R7 DAC idle in shutdown", int'(dac), 0);
            end
        end
    endtask

    task automatic t_reset();
        cs_n = 1'b0;
        sdi  = 1'b1;
        repeat (3) @(negedge sclk);
        #2;
        chk("R11 reset drive off", sdo_oe, 0);
        chk("R11 reset sampling off", sh_en, 0);
        chk("R11 reset DAC", int'(dac), 0);
        chk("R11 reset channel code", ch_sel, 0);
        chk("R11 reset shutdown", shutdown, 0);
        cs_n  = 1'b1;
        sdi   = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge sclk);
    endtask

    task automatic t_msb_first();
        vin = 12'hA5C;
        begin_txn();
        send_head(3, 1'b1, 1'b0, 1'b1, 1'b1);
        read_stream(1'b1, 1'b1, 18);
        end_txn();
        chk("R2 channel code kept despite ignored sdi", ch_sel, 2);
    endtask

    task automatic t_dual(input logic [W-1:0] code, input bit sgl, input bit odd, input int lead);
        vin = code;
        begin_txn();
        send_head(lead, sgl, odd, 1'b0, 1'b1);
        read_stream(1'b0, 1'b1, 27);
        end_txn();
    endtask

    task automatic t_shutdown_wake();
        vin = 12'h555;
        begin_txn();
        send_head(2, 1'b0, 1'b0, 1'b1, 1'b0);
        read_stream(1'b1, 1'b0, 16);
        end_txn();
        chk("R8 shutdown held while deselected", shutdown, 1);
        vin = 12'h801;
        begin_txn();
        @(posedge sclk); #2;
        chk("R8 shutdown cleared on first selected edge", shutdown, 0);
        send_head(0, 1'b1, 1'b1, 1'b1, 1'b1);
        read_stream(1'b1, 1'b1, 14);
        end_txn();
    endtask

    task automatic t_abort();
        vin = 12'h6B3;
        begin_txn();
        send_head(1, 1'b1, 1'b0, 1'b0, 1'b1);
        read_stream(1'b0, 1'b1, 6);
        end_txn();
        vin = 12'h19E;
        begin_txn();
        send_head(0, 1'b0, 1'b1, 1'b1, 1'b1);
        read_stream(1'b1, 1'b1, 15);
        end_txn();
        chk("R9 recovery channel code", ch_sel, 1);
    endtask

    initial begin
        t_reset();
        t_msb_first();
        t_dual(12'h3E1, 1'b0, 1'b1, 0);
        t_dual(12'h000, 1'b1, 1'b1, 1);
        t_dual(12'hFFF, 1'b0, 1'b0, 2);
        t_shutdown_wake();
        t_abort();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule